// File: doc/BRIEF.md
# Digital Input Acquisition Controller

This block captures words from a parallel digital input port into an internal FIFO. One 32-bit control word at bus offset 0 sets how the capture works. It sets the sampling pace, whether capture waits for a trigger, whether a request/acknowledge handshake with the data source is used, and whether two 16-bit ports are joined into one 32-bit word. The same word reports the FIFO fill state and a sticky overrun flag. Writing a one to the clear bit flushes the FIFO.

The sampling pace comes from one of four sources. The first is an edge of a timer input. The second is every cycle of the system clock, which runs at a nominal 20 MHz. The third is every second cycle of that clock. The fourth is an edge of an external request strobe. Asynchronous inputs pass through synchronizer flops before they are used. A downstream consumer drains captured words through a pop strobe and a head-of-FIFO data output.

Top module: `dinacq_ctl`

## Requirements
- R1: After reset the control word reads 0x0000_1000 (only the empty flag, bit 12, set), `ack_out` and `term_off_a` are low, and `portb_ctl_en` is high.
- R2: Bits 0, 2:1, 3, 5, 6 and 8 of a write to offset 0 are stored and read back in place. Bits 31:13, 9, 7 and 4 always read as 0, and writing them has no effect.
- R3: With bit 0 = 1 a sample is {port_b, port_a} and `portb_ctl_en` is low. With bit 0 = 0 a sample is port_a with zero upper bits, and `portb_ctl_en` is high.
- R4: Bits 2:1 choose the pace. 01 gives one sample per clock. 10 gives one sample per two clocks. 00 gives one sample per rising edge of `timer0_in`. 11 gives one sample per rising edge of `ext_req`.
- R5: With bit 5 = 1, no sample is taken after enabling until `trig_in` has been seen high. From then on, sampling continues even after `trig_in` falls.
- R6: With bit 3 = 1, each rising edge of `ext_req` captures one sample and raises `ack_out` for exactly one clock. While the FIFO is full, no capture and no acknowledge happen, and overrun is not set.
- R7: Without handshake, a pace event while the FIFO is full discards the sample and sets overrun (bit 10). Overrun stays set until a clear.
- R8: Writing 1 to bit 9 empties the FIFO and clears overrun at that same clock edge. Bit 9 reads as 0.
- R9: Bit 11 is set when the FIFO holds DEPTH words. Bit 12 is set when it holds none. Words leave in arrival order.
- R10: With bit 8 = 0, no sample is taken. Clearing bit 8 also drops a seen trigger, so re-enabling with bit 5 = 1 waits for a new trigger.
- R11: Bit 6 drives `term_off_a` as a plain level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominal 20 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register offset; only 0 is decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Control word read-back at offset 0, else zero |
| port_a | input | PORT_W | Low input port |
| port_b | input | PORT_W | High input port (used in wide mode) |
| timer0_in | input | 1 | Timer pace input (asynchronous) |
| ext_req | input | 1 | External request strobe (asynchronous) |
| trig_in | input | 1 | Start trigger (asynchronous, active high) |
| ack_out | output | 1 | Handshake acknowledge, one clock per capture |
| term_off_a | output | 1 | Port A terminator-off level |
| portb_ctl_en | output | 1 | High when port B's own control lines may be used |
| fifo_pop | input | 1 | Remove the head word |
| fifo_dout | output | 2*PORT_W | Head word of the FIFO |

## Verification
The hardest states to reach are a full FIFO in the two capture styles. In handshake mode a full FIFO must hold back both the capture and the acknowledge. In free-running mode it must set the sticky overrun. The stimulus fills the FIFO with a fixed port value. It then changes the port value and keeps pacing, and afterwards drains the FIFO. If every drained word carries the old value and the count equals the depth, the extra samples were discarded. Trigger re-arming is reached by disabling and re-enabling without a new trigger pulse, and then confirming that the FIFO stays empty.

// File: rtl/dinacq_pkg.sv
package dinacq_pkg;
   typedef enum logic [1:0] {
      SRC_TIMER = 2'b00,
      SRC_FAST  = 2'b01,
      SRC_SLOW  = 2'b10,
      SRC_EXT   = 2'b11
   } pace_src_e;

   localparam int CB_WIDE  = 0;
   localparam int CB_SRC   = 1;
   localparam int CB_HS    = 3;
   localparam int CB_WAIT  = 5;
   localparam int CB_TERM  = 6;
   localparam int CB_EN    = 8;
   localparam int CB_CLR   = 9;
   localparam int CB_OVR   = 10;
   localparam int CB_FULL  = 11;
   localparam int CB_EMPTY = 12;

   typedef struct packed {
      logic      en;
      logic      term_off;
      logic      wait_trig;
      logic      hs;
      pace_src_e src;
      logic      wide;
   } ctl_t;
endpackage

// File: rtl/dinacq_sync.sv
module dinacq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dinacq_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], d};
   end

   assign q    = sh[STAGES-1];
   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/dinacq_div.sv
module dinacq_div #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (DIV < 1) begin : g_bad_div
      $error("dinacq_div: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      assign tick = 1'b1;
   end else begin : g_count
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      cnt <= '0;
         else if (cnt == CW'(DIV - 1))    cnt <= '0;
         else                             cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CW'(DIV - 1));
   end
endmodule

// File: rtl/dinacq_pace.sv
module dinacq_pace
   import dinacq_pkg::*;
#(
   parameter int DIV_FAST    = 1,
   parameter int DIV_SLOW    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pace_src_e src,
   input  logic      timer0_in,
   input  logic      ext_req,
   output logic      tick,
   output logic      req_rise
);
   logic fast_tick, slow_tick, tmr_rise, tmr_lvl, req_lvl;

   dinacq_div #(.DIV(DIV_FAST)) u_fast (.clk(clk), .rst_n(rst_n), .tick(fast_tick));
   dinacq_div #(.DIV(DIV_SLOW)) u_slow (.clk(clk), .rst_n(rst_n), .tick(slow_tick));

   dinacq_sync #(.STAGES(SYNC_STAGES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .d(timer0_in), .q(tmr_lvl), .rise(tmr_rise));
   dinacq_sync #(.STAGES(SYNC_STAGES)) u_req (
      .clk(clk), .rst_n(rst_n), .d(ext_req), .q(req_lvl), .rise(req_rise));

   always_comb begin
      unique case (src)
         SRC_TIMER: tick = tmr_rise;
         SRC_FAST:  tick = fast_tick;
         SRC_SLOW:  tick = slow_tick;
         default:   tick = req_rise;
      endcase
   end

   logic unused_lvl;
   assign unused_lvl = tmr_lvl ^ req_lvl;
endmodule

// File: rtl/dinacq_fifo.sv
module dinacq_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("dinacq_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push & ~full & ~clr;
   assign do_pop  = pop & ~empty & ~clr;
   assign dout    = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (clr) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/dinacq_ctl.sv
module dinacq_ctl
   import dinacq_pkg::*;
#(
   parameter int PORT_W      = 16,
   parameter int DEPTH       = 8,
   parameter int ADDR_W      = 4,
   parameter int DIV_FAST    = 1,
   parameter int DIV_SLOW    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [PORT_W-1:0]   port_a,
   input  logic [PORT_W-1:0]   port_b,
   input  logic                timer0_in,
   input  logic                ext_req,
   input  logic                trig_in,
   output logic                ack_out,
   output logic                term_off_a,
   output logic                portb_ctl_en,
   input  logic                fifo_pop,
   output logic [2*PORT_W-1:0] fifo_dout
);
   localparam int SW = 2 * PORT_W;

   if (PORT_W < 1 || ADDR_W < 1) begin : g_bad_widths
      $error("dinacq_ctl: PORT_W and ADDR_W must be positive");
   end

   ctl_t          ctl_q;
   logic          hit, clr_pulse, en_q;
   logic          trig_lvl, trig_rise, trig_seen_q, active;
   logic          tick, req_rise, want, fifo_push;
   logic          fifo_full, fifo_empty, ovr_q, ack_q;
   logic [SW-1:0] sample;
   logic [31:0]   csr_view;

   assign hit       = bus_wr && (bus_addr == '0);
   assign clr_pulse = hit && bus_wdata[CB_CLR];
   assign en_q      = ctl_q.en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (hit) begin
         ctl_q.wide      <= bus_wdata[CB_WIDE];
         ctl_q.src       <= pace_src_e'(bus_wdata[CB_SRC +: 2]);
         ctl_q.hs        <= bus_wdata[CB_HS];
         ctl_q.wait_trig <= bus_wdata[CB_WAIT];
         ctl_q.term_off  <= bus_wdata[CB_TERM];
         ctl_q.en        <= bus_wdata[CB_EN];
      end
   end

   dinacq_sync #(.STAGES(SYNC_STAGES)) u_trig (
      .clk(clk), .rst_n(rst_n), .d(trig_in), .q(trig_lvl), .rise(trig_rise));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              trig_seen_q <= 1'b0;
      else if (!ctl_q.en)                      trig_seen_q <= 1'b0;
      else if (ctl_q.wait_trig && trig_lvl)    trig_seen_q <= 1'b1;
   end

   assign active = ctl_q.en && (!ctl_q.wait_trig || trig_seen_q);

   dinacq_pace #(
      .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .SYNC_STAGES(SYNC_STAGES)
   ) u_pace (
      .clk(clk), .rst_n(rst_n), .src(ctl_q.src),
      .timer0_in(timer0_in), .ext_req(ext_req),
      .tick(tick), .req_rise(req_rise));

   assign want      = active && (ctl_q.hs ? req_rise : tick);
   assign fifo_push = want && !fifo_full && !clr_pulse;
   assign sample    = ctl_q.wide ? {port_b, port_a} : {{PORT_W{1'b0}}, port_a};

   dinacq_fifo #(.W(SW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(clr_pulse),
      .push(fifo_push), .din(sample), .pop(fifo_pop),
      .dout(fifo_dout), .full(fifo_full), .empty(fifo_empty));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      ovr_q <= 1'b0;
      else if (clr_pulse)                              ovr_q <= 1'b0;
      else if (want && !ctl_q.hs && fifo_full)         ovr_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= fifo_push && ctl_q.hs;
   end

   always_comb begin
      csr_view             = '0;
      csr_view[CB_WIDE]    = ctl_q.wide;
      csr_view[CB_SRC +: 2] = ctl_q.src;
      csr_view[CB_HS]      = ctl_q.hs;
      csr_view[CB_WAIT]    = ctl_q.wait_trig;
      csr_view[CB_TERM]    = ctl_q.term_off;
      csr_view[CB_EN]      = ctl_q.en;
      csr_view[CB_OVR]     = ovr_q;
      csr_view[CB_FULL]    = fifo_full;
      csr_view[CB_EMPTY]   = fifo_empty;
   end

   assign bus_rdata    = (bus_addr == '0) ? csr_view : '0;
   assign ack_out      = ack_q;
   assign term_off_a   = ctl_q.term_off;
   assign portb_ctl_en = ~ctl_q.wide;

   logic unused_trig;
   assign unused_trig = trig_rise;
endmodule

// File: rtl/dinacq_chk.sv
module dinacq_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack,
   input logic              full,
   input logic              empty,
   input logic              ovr,
   input logic              clr,
   input logic              en,
   input logic              push,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       rdata
);
   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == '0) |-> (rdata[31:13] == '0 && !rdata[9] && !rdata[7] && !rdata[4]));

   p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   p_ack_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(!full));

   p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !clr) |=> ovr);

   p_clr_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (empty && !ovr));

   p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   p_idle_no_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !push);
endmodule

bind dinacq_ctl dinacq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ack(ack_out), .full(fifo_full),
   .empty(fifo_empty), .ovr(ovr_q), .clr(clr_pulse), .en(en_q),
   .push(fifo_push), .addr(bus_addr), .rdata(bus_rdata));

// File: tb/tb_dinacq_ctl.sv
module tb_dinacq_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] port_a = '0, port_b = '0;
   logic        timer0_in = 1'b0, ext_req = 1'b0, trig_in = 1'b0;
   logic        ack_out, term_off_a, portb_ctl_en;
   logic        fifo_pop = 1'b0;
   logic [31:0] fifo_dout;

   int checks = 0;
   int fails = 0;
   int ack_cnt;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dinacq_ctl dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_a(port_a),
      .port_b(port_b), .timer0_in(timer0_in), .ext_req(ext_req),
      .trig_in(trig_in), .ack_out(ack_out), .term_off_a(term_off_a),
      .portb_ctl_en(portb_ctl_en), .fifo_pop(fifo_pop), .fifo_dout(fifo_dout));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ack_cnt <= 0;
      else if (ack_out) ack_cnt <= ack_cnt + 1;
   end

   // {write data, expected read-back}
   localparam logic [63:0] VEC [7] = '{
      {32'hFFFF_00FF, 32'h0000_106F},
      {32'h0000_0001, 32'h0000_1001},
      {32'h0000_0006, 32'h0000_1006},
      {32'h0000_0048, 32'h0000_1048},
      {32'h0000_0090, 32'h0000_1000},
      {32'h0000_0020, 32'h0000_1020},
      {32'hFFFF_0000, 32'h0000_1000}
   };

   task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      bus_addr  = '0;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic drain(output int n, output logic [31:0] first, output logic [31:0] last);
      n = 0;
      first = '0;
      last = '0;
      while (bus_rdata[12] == 1'b0 && n < 64) begin
         if (n == 0) first = fifo_dout;
         last = fifo_dout;
         fifo_pop = 1'b1;
         @(negedge clk);
         fifo_pop = 1'b0;
         n++;
      end
   endtask

   task automatic pulses(input int which, input int n);
      for (int i = 0; i < n; i++) begin
         if (which == 0) timer0_in = 1'b1; else ext_req = 1'b1;
         repeat (3) @(negedge clk);
         if (which == 0) timer0_in = 1'b0; else ext_req = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int n, a0;
      logic [31:0] f, l;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_eq("R1 csr", bus_rdata, 32'h0000_1000);
      check_eq("R1 outs", {29'b0, ack_out, term_off_a, portb_ctl_en}, 32'h1);

      // R2 / R11 / R3 register table
      for (int i = 0; i < 7; i++) begin
         wr(VEC[i][63:32]);
         check_eq("R2 readback", bus_rdata, VEC[i][31:0]);
         check_eq("R11 term level", {31'b0, term_off_a}, {31'b0, VEC[i][6]});
         check_eq("R3 portb ctl", {31'b0, portb_ctl_en}, {31'b0, ~VEC[i][0]});
      end
      bus_addr = 4'h1;
      @(negedge clk);
      check_eq("R2 other offset", bus_rdata, 32'h0);
      bus_addr = 4'h0;

      // R4 fast pace, R3 narrow data
      port_a = 16'hA5A5; port_b = 16'h3C3C;
      wr(32'h102); repeat (3) @(negedge clk); wr(32'h002);
      drain(n, f, l);
      check_eq("R4 fast count", n, 4);
      check_eq("R3 narrow data", f, 32'h0000_A5A5);

      // R3 wide data
      wr(32'h103); repeat (1) @(negedge clk); wr(32'h003);
      drain(n, f, l);
      check_eq("R3 wide count", n, 2);
      check_eq("R3 wide data", l, 32'h3C3C_A5A5);

      // R4 slow pace
      wr(32'h104); repeat (5) @(negedge clk); wr(32'h004);
      drain(n, f, l);
      check_eq("R4 slow count", n, 3);

      // R4 timer pace
      wr(32'h100); pulses(0, 3); repeat (4) @(negedge clk); wr(32'h000);
      drain(n, f, l);
      check_eq("R4 timer count", n, 3);

      // R4 external pace, no handshake
      wr(32'h106); pulses(1, 2); repeat (4) @(negedge clk); wr(32'h006);
      drain(n, f, l);
      check_eq("R4 ext count", n, 2);
      check_eq("R6 no ack without hs", {31'b0, ack_out}, 32'h0);

      // R6 handshake
      a0 = ack_cnt;
      wr(32'h10E); pulses(1, 3); repeat (4) @(negedge clk); wr(32'h00E);
      check_eq("R6 ack count", ack_cnt - a0, 3);
      drain(n, f, l);
      check_eq("R6 hs samples", n, 3);

      // R6 / R9 handshake with full FIFO
      a0 = ack_cnt;
      wr(32'h10E); pulses(1, 10); repeat (4) @(negedge clk);
      check_eq("R9 full flag hs", bus_rdata[12:10], 3'b010);
      check_eq("R6 ack withheld", ack_cnt - a0, 8);
      wr(32'h00E);
      drain(n, f, l);
      check_eq("R6 hs full count", n, 8);

      // R7 overrun, discarded samples
      port_a = 16'h1111;
      wr(32'h102); repeat (10) @(negedge clk);
      port_a = 16'h2222;
      repeat (4) @(negedge clk);
      check_eq("R7 ovr+full", bus_rdata[12:10], 3'b011);
      wr(32'h002);
      repeat (3) @(negedge clk);
      check_eq("R7 ovr sticky", {31'b0, bus_rdata[10]}, 32'h1);
      drain(n, f, l);
      check_eq("R9 depth count", n, 8);
      check_eq("R7 discarded", l, 32'h0000_1111);
      check_eq("R7 ovr after drain", bus_rdata, 32'h0000_1402);

      // R8 clear while full and overrun
      wr(32'h102); repeat (12) @(negedge clk);
      check_eq("R9 full again", bus_rdata[12:10], 3'b011);
      wr(32'h202);
      check_eq("R8 clear", bus_rdata, 32'h0000_1002);

      // R5 trigger wait
      wr(32'h122); repeat (10) @(negedge clk);
      check_eq("R5 held off", bus_rdata[12:10], 3'b100);
      trig_in = 1'b1; repeat (2) @(negedge clk); trig_in = 1'b0;
      repeat (20) @(negedge clk);
      check_eq("R5 runs after trigger", bus_rdata[12:10], 3'b011);

      // R10 disable drops trigger
      wr(32'h222);
      check_eq("R10 cleared", bus_rdata, 32'h0000_1022);
      repeat (5) @(negedge clk);
      check_eq("R10 idle", bus_rdata, 32'h0000_1022);
      wr(32'h122); repeat (10) @(negedge clk);
      check_eq("R10 rearmed", bus_rdata, 32'h0000_1122);
      wr(32'h022);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule